// File: doc/BRIEF.md
# Torus Shortest-Path XY Router

This block is one node router for a two-dimensional torus of processing nodes. The nodes exchange address-event packets that carry synaptic data. The router has five ports: four neighbour ports (East, South, West, North) and one local port. Each port has a valid/ready handshake in both directions. Every input keeps arriving packets in a small first-in first-out buffer.

For the packet at the head of each buffer, the router compares the destination coordinates with the node's own coordinates. The node's coordinates come from configuration inputs and are 1-based. Routing is dimension-ordered: the packet first travels horizontally until its column matches, then vertically. In each dimension the router measures the hop count in both directions around the ring and takes the shorter one. When the two counts are equal it takes the direction that does not wrap. A packet that has arrived at its node is handed to the local port.

Each output has its own round-robin arbiter over the five inputs. Once an output presents a packet, it holds that packet until the downstream side accepts it.

Top module: `torus_router`

## Requirements
- R1: After reset every input ready is high and every output valid is low.
- R2: Ports are indexed 0 East, 1 South, 2 West, 3 North, 4 Local. A packet whose destination column and row both equal cfgX and cfgY leaves on port 4.
- R3: A packet whose destination column differs from cfgX leaves on port 0 or 2, whatever its destination row. Only a packet whose column matches may leave on port 1 or 3.
- R4: With destination column dx > cfgX, the packet goes East when (dx - cfgX) <= (WN - dx + cfgX), and West otherwise.
- R5: With dx < cfgX, the packet goes West when (cfgX - dx) <= (WN - cfgX + dx), and East otherwise.
- R6: With the column matched and destination row dy > cfgY, the packet goes South when (dy - cfgY) <= (HN - dy + cfgY), and North otherwise. With dy < cfgY, it goes North when (cfgY - dy) <= (HN - cfgY + dy), and South otherwise.
- R7: Each input buffers up to 4 packets. Its ready is low exactly while 4 are held, so a fifth offered packet is not taken. Packets from one input leave in arrival order.
- R8: While an output's valid is high and its ready is low, the next cycle shows the same valid and the same data.
- R9: The arbiter of each output searches the inputs in cyclic order 0..4. It starts one past the input that last completed a transfer on that output, and it starts at input 0 after reset.
- R10: Packets are 32 bits, laid out as {dest_x[31:28], dest_y[27:24], payload[23:0]}. They leave the router bit-for-bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgX | input | 4 | Column of this node, 1-based |
| cfgY | input | 4 | Row of this node, 1-based |
| inValid | input | 5 | Per-input packet valid, bit index = port index |
| inReady | output | 5 | Per-input ready (buffer not full) |
| inData | input | 160 | Input packets, port p at bits [32p+31:32p] |
| outValid | output | 5 | Per-output packet valid |
| outReady | input | 5 | Per-output downstream ready |
| outData | output | 160 | Output packets, port p at bits [32p+31:32p] |

## Verification
Several kinds of wrong state show up at the ports. A buffer pointer or count that is off appears at once as a wrong head packet, a reordered packet or a ready that drops early or late. The reference model compares every cycle, so it catches these in the cycle the head is first presented. A wrong arbiter pointer or hold flag changes which input wins on the next contended cycle, and a lost hold shows on the next stalled cycle as changed data. Routing faults appear on the first packet whose distance lands on a tie or on a wrap, which is why the directed cases sit on those boundaries.

// File: rtl/torus_router_pkg.sv
package torus_router_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    P_EAST  = 3'd0,
    P_SOUTH = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_LOCAL = 3'd4
  } portT;

  // strobes from control to datapath
  typedef struct packed {
    logic [NPORT-1:0]      pop;
    logic [NPORT-1:0][2:0] sel;
  } strobeT;
endpackage

// File: rtl/trx_datapath.sv
module trx_datapath
  import torus_router_pkg::*;
#(
  parameter int PW    = 32,
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPORT-1:0]   inValid,
  output logic [NPORT-1:0]   inReady,
  input  logic [NPORT*PW-1:0] inData,
  input  strobeT             st,
  output logic [NPORT-1:0]   notEmpty,
  output logic [NPORT*PW-1:0] headData,
  output logic [NPORT*PW-1:0] outData
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] headArr [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : gIn
    logic [PW-1:0] mem [DEPTH];
    logic [AW-1:0] wrPtr, rdPtr;
    logic [AW:0]   count;
    logic          push;

    assign push = inValid[p] && inReady[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (push)
          wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
        if (st.pop[p])
          rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
        count <= count + (AW+1)'(push) - (AW+1)'(st.pop[p]);
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wrPtr] <= inData[p*PW +: PW];
    end

    assign inReady[p]             = (count != (AW+1)'(DEPTH));
    assign notEmpty[p]            = (count != '0);
    assign headArr[p]             = mem[rdPtr];
    assign headData[p*PW +: PW]   = headArr[p];
  end

  for (genvar o = 0; o < NPORT; o++) begin : gMux
    assign outData[o*PW +: PW] = headArr[st.sel[o]];
  end
endmodule

// File: rtl/trx_control.sv
module trx_control
  import torus_router_pkg::*;
#(
  parameter int WN = 8,
  parameter int HN = 8,
  parameter int CW = 4,
  parameter int PW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CW-1:0]       cfgX,
  input  logic [CW-1:0]       cfgY,
  input  logic [NPORT-1:0]    notEmpty,
  input  logic [NPORT*PW-1:0] headData,
  input  logic [NPORT-1:0]    outReady,
  output logic [NPORT-1:0]    outValid,
  output strobeT              st
);
  portT                  route [NPORT];
  logic [NPORT-1:0][2:0] grant;
  logic [NPORT-1:0]      xfer;
  logic [NPORT-1:0]      popV;

  function automatic portT pickDir(input logic [CW-1:0] dst, input logic [CW-1:0] own,
                                   input int ring, input portT upDir, input portT downDir);
    int direct, wrap;
    if (dst > own) begin
      direct = int'(dst) - int'(own);
      wrap   = ring - int'(dst) + int'(own);
      return (direct <= wrap) ? upDir : downDir;
    end
    direct = int'(own) - int'(dst);
    wrap   = ring - int'(own) + int'(dst);
    return (direct <= wrap) ? downDir : upDir;
  endfunction

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      logic [CW-1:0] dx, dy;
      dx = headData[i*PW + PW-1 -: CW];
      dy = headData[i*PW + PW-CW-1 -: CW];
      if (dx != cfgX)      route[i] = pickDir(dx, cfgX, WN, P_EAST, P_WEST);
      else if (dy != cfgY) route[i] = pickDir(dy, cfgY, HN, P_SOUTH, P_NORTH);
      else                 route[i] = P_LOCAL;
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : gArb
    logic [NPORT-1:0] req;
    logic [2:0]       ptr, lockIdx, pick;
    logic             locked, found;

    always_comb begin
      int j;
      for (int i = 0; i < NPORT; i++)
        req[i] = notEmpty[i] && (route[i] == portT'(o));
      pick  = '0;
      found = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
        j = int'(ptr) + k;
        if (j >= NPORT) j = j - NPORT;
        if (!found && req[j]) begin
          pick  = 3'(j);
          found = 1'b1;
        end
      end
    end

    assign grant[o]    = locked ? lockIdx : pick;
    assign outValid[o] = locked || found;
    assign xfer[o]     = outValid[o] && outReady[o];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptr     <= '0;
        locked  <= 1'b0;
        lockIdx <= '0;
      end else if (xfer[o]) begin
        locked <= 1'b0;
        ptr    <= (grant[o] == 3'(NPORT-1)) ? '0 : grant[o] + 3'd1;
      end else if (outValid[o]) begin
        locked  <= 1'b1;
        lockIdx <= grant[o];
      end
    end
  end

  always_comb begin
    popV = '0;
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        if (xfer[o] && grant[o] == 3'(i)) popV[i] = 1'b1;
  end

  assign st = '{pop: popV, sel: grant};
endmodule

// File: rtl/torus_router.sv
module torus_router
  import torus_router_pkg::*;
#(
  parameter int WN    = 8,
  parameter int HN    = 8,
  parameter int CW    = 4,
  parameter int PLW   = 24,
  parameter int DEPTH = 4,
  localparam int PW   = 2*CW + PLW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CW-1:0]       cfgX,
  input  logic [CW-1:0]       cfgY,
  input  logic [NPORT-1:0]    inValid,
  output logic [NPORT-1:0]    inReady,
  input  logic [NPORT*PW-1:0] inData,
  output logic [NPORT-1:0]    outValid,
  input  logic [NPORT-1:0]    outReady,
  output logic [NPORT*PW-1:0] outData
);
  strobeT              st;
  logic [NPORT-1:0]    notEmpty;
  logic [NPORT*PW-1:0] headData;

  trx_datapath #(.PW(PW), .DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .st(st), .notEmpty(notEmpty), .headData(headData), .outData(outData)
  );

  trx_control #(.WN(WN), .HN(HN), .CW(CW), .PW(PW)) uCtl (
    .clk(clk), .rstN(rstN), .cfgX(cfgX), .cfgY(cfgY), .notEmpty(notEmpty),
    .headData(headData), .outReady(outReady), .outValid(outValid), .st(st)
  );
endmodule

// File: rtl/torus_router_chk.sv
module torus_router_chk
  import torus_router_pkg::*;
#(
  parameter int CW  = 4,
  parameter int PLW = 24,
  localparam int PW = 2*CW + PLW
) (
  input logic                clk,
  input logic                rstN,
  input logic [CW-1:0]       cfgX,
  input logic [CW-1:0]       cfgY,
  input logic [NPORT-1:0]    outValid,
  input logic [NPORT-1:0]    outReady,
  input logic [NPORT*PW-1:0] outData
);
  localparam int LB = 4*PW;
  localparam int EB = 0;
  localparam int SB = 1*PW;
  localparam int WB = 2*PW;
  localparam int NB = 3*PW;

  for (genvar o = 0; o < NPORT; o++) begin : gHold
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o]); // R8
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> $stable(outData[o*PW +: PW])); // R8
  end

  AST_LOCAL_DEST: assert property (@(posedge clk) disable iff (!rstN)
    outValid[4] |-> (outData[LB+PW-1 -: CW] == cfgX && outData[LB+PW-CW-1 -: CW] == cfgY)); // R2
  AST_EAST_XFIRST: assert property (@(posedge clk) disable iff (!rstN)
    outValid[0] |-> outData[EB+PW-1 -: CW] != cfgX); // R3
  AST_WEST_XFIRST: assert property (@(posedge clk) disable iff (!rstN)
    outValid[2] |-> outData[WB+PW-1 -: CW] != cfgX); // R3
  AST_SOUTH_XDONE: assert property (@(posedge clk) disable iff (!rstN)
    outValid[1] |-> outData[SB+PW-1 -: CW] == cfgX); // R3
  AST_NORTH_XDONE: assert property (@(posedge clk) disable iff (!rstN)
    outValid[3] |-> outData[NB+PW-1 -: CW] == cfgX); // R3
endmodule

bind torus_router torus_router_chk #(.CW(CW), .PLW(PLW)) uChk (.*);

// File: tb/tb_torus_router.sv
`timescale 1ns/1ps
module tb_torus_router;
  import torus_router_pkg::*;
  localparam int WN = 8, HN = 8, CW = 4, PLW = 24, DEPTH = 4;
  localparam int PW = 2*CW + PLW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] cfgX, cfgY;
  logic [NPORT-1:0] inValid, inReady, outValid, outReady;
  logic [NPORT*PW-1:0] inData, outData;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [PW-1:0] q [NPORT][$];
  int  mPtr [NPORT];
  bit  mLock [NPORT];
  int  mLockIdx [NPORT];
  bit  expV [NPORT];
  int  expI [NPORT];

  always #2 clk = ~clk;

  torus_router dut (
    .clk(clk), .rstN(rstN), .cfgX(cfgX), .cfgY(cfgY),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(bit ok, string tag, string act, string exp_);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp_);
    end
  endtask

  function automatic logic [PW-1:0] mk(int dx, int dy, int pl);
    return {CW'(dx), CW'(dy), PLW'(pl)};
  endfunction

  // hop counts around each ring decide the port
  function automatic int refRoute(logic [PW-1:0] p);
    int dx = int'(p[PW-1 -: CW]);
    int dy = int'(p[PW-CW-1 -: CW]);
    int cx = int'(cfgX);
    int cy = int'(cfgY);
    int fwd, back;
    if (dx != cx) begin
      fwd  = (dx - cx + WN) % WN;
      back = (cx - dx + WN) % WN;
      if (dx > cx) return (fwd <= back) ? 0 : 2;
      return (back <= fwd) ? 2 : 0;
    end
    if (dy != cy) begin
      fwd  = (dy - cy + HN) % HN;
      back = (cy - dy + HN) % HN;
      if (dy > cy) return (fwd <= back) ? 1 : 3;
      return (back <= fwd) ? 3 : 1;
    end
    return 4;
  endfunction

  task automatic computeExp();
    for (int o = 0; o < NPORT; o++) begin
      expV[o] = 1'b0;
      expI[o] = 0;
      if (mLock[o]) begin
        expV[o] = 1'b1;
        expI[o] = mLockIdx[o];
      end else begin
        for (int k = 0; k < NPORT; k++) begin
          int j = (mPtr[o] + k) % NPORT;
          if (!expV[o] && q[j].size() > 0 && refRoute(q[j][0]) == o) begin
            expV[o] = 1'b1;
            expI[o] = j;
          end
        end
      end
    end
  endtask

  // compare with the model, then advance it across the coming edge
  task automatic cycle(string tag);
    bit rdy [NPORT];
    bit ok;
    logic [NPORT-1:0] ev, er;
    logic [NPORT*PW-1:0] ed;
    #1;
    computeExp();
    ok = 1'b1;
    ed = outData;
    for (int o = 0; o < NPORT; o++) begin
      ev[o] = expV[o];
      if (expV[o]) ed[o*PW +: PW] = q[expI[o]][0];
      if (outValid[o] !== ev[o]) ok = 1'b0;
      else if (expV[o] && outData[o*PW +: PW] !== ed[o*PW +: PW]) ok = 1'b0;
    end
    for (int i = 0; i < NPORT; i++) begin
      rdy[i] = (q[i].size() < DEPTH);
      er[i]  = rdy[i];
      if (inReady[i] !== er[i]) ok = 1'b0;
    end
    check(ok, tag,
          $sformatf("v=%b r=%b d=%h", outValid, inReady, outData),
          $sformatf("v=%b r=%b d=%h", ev, er, ed));
    for (int o = 0; o < NPORT; o++) begin
      if (expV[o]) begin
        if (outReady[o]) begin
          void'(q[expI[o]].pop_front());
          mPtr[o]  = (expI[o] + 1) % NPORT;
          mLock[o] = 1'b0;
        end else begin
          mLock[o]    = 1'b1;
          mLockIdx[o] = expI[o];
        end
      end
    end
    for (int i = 0; i < NPORT; i++)
      if (inValid[i] && rdy[i]) q[i].push_back(inData[i*PW +: PW]);
    @(negedge clk);
  endtask

  task automatic probe(string tag, int dx, int dy, int port);
    logic [NPORT-1:0] want;
    want = NPORT'(1) << port;
    inData[4*PW +: PW] = mk(dx, dy, 16*dx + dy);
    inValid  = 5'b10000;
    outReady = '0;
    cycle(tag);
    inValid = '0;
    check(outValid == want, tag, $sformatf("%b", outValid), $sformatf("%b", want));
    outReady = '1;
    cycle(tag);
    outReady = '0;
    cycle(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PLW-1:0] held;
    logic [PLW-1:0] seq [4];
    inValid  = '0;
    outReady = '0;
    inData   = '0;
    cfgX     = 4'd2;
    cfgY     = 4'd3;
    for (int o = 0; o < NPORT; o++) begin
      mPtr[o] = 0; mLock[o] = 1'b0; mLockIdx[o] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 5'h1f && outValid == 5'h00, "R1 reset",
          $sformatf("r=%b v=%b", inReady, outValid), "r=11111 v=00000");
    cycle("R1 idle");

    // node (2,3)
    probe("R2 local", 2, 3, 4);
    probe("R3 R4 x before y", 5, 7, 0);
    probe("R4 tie east", 6, 3, 0);
    probe("R4 wrap west", 7, 3, 2);
    probe("R3 R5 direct west", 1, 3, 2);

    // node (6,6)
    cfgX = 4'd6; cfgY = 4'd6;
    cycle("R5 cfg");
    probe("R5 tie west", 2, 6, 2);
    probe("R5 wrap east", 1, 6, 0);
    probe("R6 direct south", 6, 8, 1);
    probe("R6 tie north", 6, 2, 3);
    probe("R6 wrap south", 6, 1, 1);
    probe("R6 near south", 6, 7, 1);
    probe("R3 direct west", 3, 6, 2);
    probe("R2 local", 6, 6, 4);

    // buffer depth and order
    outReady = '0;
    for (int k = 0; k < 5; k++) begin
      inData[0 +: PW] = mk(6, 6, k + 1);
      inValid = 5'b00001;
      cycle("R7 fill");
    end
    inValid = '0;
    check(inReady[0] == 1'b0, "R7 full", $sformatf("%b", inReady[0]), "0");
    outReady = 5'b10000;
    repeat (4) cycle("R7 drain order");
    check(outValid == 5'b00000, "R7 fifth dropped", $sformatf("%b", outValid), "00000");
    outReady = '0;

    // hold under stall
    inData[4*PW +: PW] = mk(6, 6, 24'h5a5a5a);
    inValid = 5'b10000;
    cycle("R8 push");
    inValid = '0;
    held = outData[4*PW +: PLW];
    repeat (3) cycle("R8 stall");
    check(outValid[4] && outData[4*PW +: PLW] == held, "R8 stable",
          $sformatf("%b %h", outValid[4], outData[4*PW +: PLW]), $sformatf("1 %h", held));
    outReady = '1;
    cycle("R8 release");
    outReady = '0;

    // round robin: pointer at 0 after last local grant from input 4
    for (int i = 0; i < 4; i++) inData[i*PW +: PW] = mk(6, 6, i);
    inValid = 5'b01111;
    cycle("R9 load");
    inValid  = '0;
    outReady = 5'b10000;
    for (int k = 0; k < 4; k++) begin
      seq[k] = outData[4*PW +: PLW];
      cycle("R9 rotate");
    end
    check(seq[0] == 0 && seq[1] == 1 && seq[2] == 2 && seq[3] == 3, "R9 order",
          $sformatf("%0d %0d %0d %0d", seq[0], seq[1], seq[2], seq[3]), "0 1 2 3");
    outReady = '0;
    inData[0 +: PW]    = mk(6, 6, 0);
    inData[4*PW +: PW] = mk(6, 6, 4);
    inValid = 5'b10001;
    cycle("R9 load2");
    inValid  = '0;
    outReady = 5'b10000;
    seq[0] = outData[4*PW +: PLW];
    cycle("R9 rotate2");
    seq[1] = outData[4*PW +: PLW];
    cycle("R9 rotate2");
    check(seq[0] == 4 && seq[1] == 0, "R9 wrap order",
          $sformatf("%0d %0d", seq[0], seq[1]), "4 0");
    outReady = '0;
    cycle("R9 idle");

    // random traffic against the model
    cfgX = 4'd2; cfgY = 4'd3;
    cycle("R10 cfg");
    for (int n = 0; n < 4000; n++) begin
      inValid  = NPORT'($urandom);
      outReady = NPORT'($urandom) | NPORT'($urandom);
      for (int i = 0; i < NPORT; i++)
        inData[i*PW +: PW] = mk(1 + int'($urandom % 8), 1 + int'($urandom % 8), int'($urandom));
      cycle("R8 R9 R10 random");
    end
    inValid  = '0;
    outReady = '1;
    repeat (30) cycle("R10 drain");
    check(outValid == 5'b0 && inReady == 5'h1f, "R7 R10 empty",
          $sformatf("v=%b r=%b", outValid, inReady), "v=00000 r=11111");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule